// File: doc/BRIEF.md
# Miss Tracker with Read Coalescing and Atomic Counting

This block keeps a small, fully associative table of in-flight transactions for a cache, one entry per line address. An entry remembers whether the line waits for a read fill or for atomic results. It also holds a bitmap of the requesters that must be answered and a count of atomics still outstanding downstream. Requests arrive on a valid/ready port. The block decides whether each request needs to go to memory and reports that decision one cycle later on a forward port. Readers that arrive while a read of the same line is pending are merged into the entry and are not forwarded a second time.

Atomic results come back on the acknowledge pins, and each one lowers the count. When the count falls to zero, the block posts a trigger to itself for the next cycle. If no new atomic reached the entry by then, the entry retires and a done pulse names the line. A separate deallocate input frees an entry in any state, which is how the surrounding logic closes a read once the fill has been delivered. A combinational lookup port exposes any entry's state, bitmap and count.

Back-pressure: a request is taken only in a cycle where `req_valid` and `req_ready` are both high. The sender may change or drop a request that was not taken. The forward, done, acknowledge and deallocate pins have no handshake: the forward and done pulses last one cycle, and an acknowledge or deallocate is acted on in the cycle it is presented.

Top module: `mt_tracker`

## Requirements
- R1: After reset no entry is live: `full`=0, `lookup_hit`=0, `fwd_valid`=0, `done_valid`=0 and `req_ready`=1 for any request with no deallocate active.
- R2: A taken read (`req_kind`=0) to a line with no entry allocates one. The new entry is read-pending (`lookup_state`=1), holds only the requester's bit (bit `req_src`) and a count of 0. In the next cycle `fwd_valid`=1 with the request's kind, address and source.
- R3: A taken read to a read-pending line ORs the requester's bit into the bitmap. It is forwarded only if the bitmap then holds exactly one bit: the same sole reader again is forwarded, and a different reader is merged silently.
- R4: A write (`req_kind`=2 or 3) never allocates an entry and never touches a bitmap. With no entry for the line it is taken and forwarded. With an entry present it is held off (`req_ready`=0).
- R5: A taken atomic (`req_kind`=1) allocates an atomic-pending entry (`lookup_state`=2) if none exists, adds its requester's bit, raises the count by one and is always forwarded.
- R6: `req_ready` is 0 for a read to an atomic-pending line, for an atomic to a read-pending line, and for an atomic to a line whose count is already at its maximum (2^CNT_W-1).
- R7: An acknowledge to an atomic-pending line with a nonzero count lowers the count by one. An acknowledge to an absent line, to a read-pending line or to a zero count has no effect. An atomic taken in the same cycle as an acknowledge to the same line leaves the count unchanged.
- R8: When an acknowledge takes a count from 1 to 0, the next cycle is the trigger cycle. If no atomic to that line is taken in the trigger cycle, the entry is freed and `done_valid`=1 with `done_addr` in the following cycle. If an atomic is taken in the trigger cycle, the entry stays with a count of 1 and no done pulse follows.
- R9: A deallocate frees the line's entry in any state and clears its bitmap, without a done pulse, even if a trigger was pending. A request to the same line in the same cycle is held off.
- R10: `full` is 1 exactly when every entry is live. While it is high, a read or atomic to a line with no entry is held off, and requests that hit an existing entry are still taken.
- R11: The lookup outputs reflect the table in the same cycle. On a miss, `lookup_state`, `lookup_mask` and `lookup_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | 0 read, 1 atomic, 2/3 write |
| req_addr | input | ADDR_W | Line address of the request |
| req_src | input | $clog2(REQ_N) | Requester index |
| ack_valid | input | 1 | An atomic result returned |
| ack_addr | input | ADDR_W | Line of the returned atomic |
| dealloc_valid | input | 1 | Free the entry of a line |
| dealloc_addr | input | ADDR_W | Line to free |
| lookup_addr | input | ADDR_W | Line to inspect |
| lookup_hit | output | 1 | Line has a live entry |
| lookup_state | output | 2 | 0 none, 1 read-pending, 2 atomic-pending |
| lookup_mask | output | REQ_N | Requester bitmap of the line |
| lookup_count | output | CNT_W | Outstanding atomics of the line |
| full | output | 1 | No free entry |
| fwd_valid | output | 1 | Forward-to-memory pulse |
| fwd_kind | output | 2 | Kind of the forwarded request |
| fwd_addr | output | ADDR_W | Address of the forwarded request |
| fwd_src | output | $clog2(REQ_N) | Requester of the forwarded request |
| done_valid | output | 1 | An atomic entry retired |
| done_addr | output | ADDR_W | Line that retired |

## Verification
The sensitive overlap is an atomic request and an atomic acknowledge landing on the same entry in one cycle. A close relative is a new atomic arriving in the very cycle the self-posted trigger is evaluated. The bench provokes both on purpose: it presents an acknowledge together with an atomic to the same line, and it follows a final acknowledge with an atomic one cycle later. It then judges the count on the lookup port and the presence or absence of the done pulse. A randomized phase over six addresses makes such collisions common, including deallocation against a pending trigger, and a behavioural model compares every output on every clock.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_READ = 2'd1,
    ST_ATOM = 2'd2
  } mt_state_e;

  localparam logic [1:0] KIND_READ = 2'd0;
  localparam logic [1:0] KIND_ATOM = 2'd1;

endpackage

// File: rtl/mt_match.sv
module mt_match #(
  parameter int N  = 4,
  parameter int AW = 16
) (
  input  logic [N-1:0]    valid_i,
  input  logic [N*AW-1:0] tags_i,
  input  logic [AW-1:0]   addr_i,
  output logic [N-1:0]    hit_o
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (tags_i[i*AW +: AW] == addr_i);
  end

endmodule

// File: rtl/mt_pick.sv
module mt_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] busy_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  always_comb begin
    grant_o = '0;
    any_o   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!busy_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        any_o      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mt_entry.sv
module mt_entry
  import mt_pkg::*;
#(
  parameter int AW = 16,
  parameter int RN = 8,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  mt_state_e     alloc_state_i,
  input  logic [RN-1:0] add_i,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          free_i,
  output mt_state_e     state_o,
  output logic [AW-1:0] addr_o,
  output logic [RN-1:0] mask_o,
  output logic [CW-1:0] cnt_o,
  output logic          retire_o
);

  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  mt_state_e     state_q;
  logic [AW-1:0] addr_q;
  logic [RN-1:0] mask_q;
  logic [CW-1:0] cnt_q;
  logic          trig_q;
  logic [CW-1:0] inc_v;
  logic [CW-1:0] dec_v;

  assign inc_v    = {{(CW-1){1'b0}}, inc_i};
  assign dec_v    = {{(CW-1){1'b0}}, dec_i};
  // The self-posted trigger retires the entry unless an atomic refilled it
  // in the trigger cycle or a deallocate already frees it.
  assign retire_o = trig_q && !inc_i && !free_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FREE;
      addr_q  <= '0;
      mask_q  <= '0;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      trig_q <= dec_i && !inc_i && !free_i && (cnt_q == ONE);
      if (free_i || retire_o) begin
        state_q <= ST_FREE;
        mask_q  <= '0;
        cnt_q   <= '0;
      end else if (alloc_i) begin
        state_q <= alloc_state_i;
        addr_q  <= alloc_addr_i;
        mask_q  <= add_i;
        cnt_q   <= inc_v;
      end else if (state_q != ST_FREE) begin
        mask_q <= mask_q | add_i;
        cnt_q  <= cnt_q + inc_v - dec_v;
      end
    end
  end

  assign state_o = state_q;
  assign addr_o  = addr_q;
  assign mask_o  = mask_q;
  assign cnt_o   = cnt_q;

endmodule

// File: rtl/mt_tracker.sv
module mt_tracker
  import mt_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int REQ_N   = 8,
  parameter int CNT_W   = 3,
  localparam int SRC_W  = $clog2(REQ_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SRC_W-1:0]  req_src,
  input  logic              ack_valid,
  input  logic [ADDR_W-1:0] ack_addr,
  input  logic              dealloc_valid,
  input  logic [ADDR_W-1:0] dealloc_addr,
  input  logic [ADDR_W-1:0] lookup_addr,
  output logic              lookup_hit,
  output logic [1:0]        lookup_state,
  output logic [REQ_N-1:0]  lookup_mask,
  output logic [CNT_W-1:0]  lookup_count,
  output logic              full,
  output logic              fwd_valid,
  output logic [1:0]        fwd_kind,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [SRC_W-1:0]  fwd_src,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_addr
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Entry storage views
  mt_state_e          ent_state [ENTRIES];
  logic [ADDR_W-1:0]  ent_addr  [ENTRIES];
  logic [REQ_N-1:0]   ent_mask  [ENTRIES];
  logic [CNT_W-1:0]   ent_cnt   [ENTRIES];
  logic [ENTRIES-1:0] retire_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES*ADDR_W-1:0] tag_flat;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_flat
    assign tag_flat[i*ADDR_W +: ADDR_W] = ent_addr[i];
    assign valid_vec[i] = (ent_state[i] != ST_FREE);
  end

  // Address match for each port
  logic [ENTRIES-1:0] req_hv, ack_hv, dal_hv, lk_hv;

  mt_match #(.N(ENTRIES), .AW(ADDR_W)) u_match_req (
    .valid_i(valid_vec), .tags_i(tag_flat), .addr_i(req_addr), .hit_o(req_hv));
  mt_match #(.N(ENTRIES), .AW(ADDR_W)) u_match_ack (
    .valid_i(valid_vec), .tags_i(tag_flat), .addr_i(ack_addr), .hit_o(ack_hv));
  mt_match #(.N(ENTRIES), .AW(ADDR_W)) u_match_dal (
    .valid_i(valid_vec), .tags_i(tag_flat), .addr_i(dealloc_addr), .hit_o(dal_hv));
  mt_match #(.N(ENTRIES), .AW(ADDR_W)) u_match_lk (
    .valid_i(valid_vec), .tags_i(tag_flat), .addr_i(lookup_addr), .hit_o(lk_hv));

  // Free entry selection
  logic [ENTRIES-1:0] free_grant;
  logic               has_free;

  mt_pick #(.N(ENTRIES)) u_pick (
    .busy_i(valid_vec), .grant_o(free_grant), .any_o(has_free));

  assign full = !has_free;

  // Field selection for the request and lookup matches
  mt_state_e         hit_state;
  logic [REQ_N-1:0]  hit_mask;
  logic [CNT_W-1:0]  hit_cnt;
  mt_state_e         lk_state;
  logic [REQ_N-1:0]  lk_mask;
  logic [CNT_W-1:0]  lk_cnt;
  logic [ADDR_W-1:0] retire_addr;

  always_comb begin
    hit_state   = ST_FREE;
    hit_mask    = '0;
    hit_cnt     = '0;
    lk_state    = ST_FREE;
    lk_mask     = '0;
    lk_cnt      = '0;
    retire_addr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (req_hv[i]) begin
        hit_state = ent_state[i];
        hit_mask  = ent_mask[i];
        hit_cnt   = ent_cnt[i];
      end
      if (lk_hv[i]) begin
        lk_state = ent_state[i];
        lk_mask  = ent_mask[i];
        lk_cnt   = ent_cnt[i];
      end
      if (retire_vec[i]) retire_addr = ent_addr[i];
    end
  end

  // Request acceptance and forwarding decision
  logic             is_write, is_atom, is_read;
  logic             req_hit, same_dal, blocked, need_alloc, fire, do_fwd;
  logic [REQ_N-1:0] src_bit;

  assign src_bit  = {{(REQ_N-1){1'b0}}, 1'b1} << req_src;
  assign is_write = req_kind[1];
  assign is_atom  = (req_kind == KIND_ATOM);
  assign is_read  = (req_kind == KIND_READ);
  assign req_hit  = |req_hv;
  assign same_dal = dealloc_valid && (dealloc_addr == req_addr);

  always_comb begin
    if (same_dal)      blocked = 1'b1;
    else if (is_write) blocked = req_hit;
    else if (req_hit) begin
      if (is_read) blocked = (hit_state == ST_ATOM);
      else         blocked = (hit_state == ST_READ) || (hit_cnt == CNT_MAX);
    end else       blocked = !has_free;
  end

  assign req_ready  = !blocked;
  assign need_alloc = !req_hit && !is_write;
  assign fire       = req_valid && req_ready;
  // A read goes out only when no other requester already waits on the line.
  assign do_fwd     = fire && (is_write || is_atom || !req_hit ||
                               ((hit_mask & ~src_bit) == '0));

  // Entry array
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic target;
    assign target = req_hv[i] || (need_alloc && free_grant[i]);

    mt_entry #(.AW(ADDR_W), .RN(REQ_N), .CW(CNT_W)) u_entry (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (fire && need_alloc && free_grant[i]),
      .alloc_addr_i (req_addr),
      .alloc_state_i(is_atom ? ST_ATOM : ST_READ),
      .add_i        ((fire && !is_write && target) ? src_bit : '0),
      .inc_i        (fire && is_atom && target),
      .dec_i        (ack_valid && ack_hv[i] && (ent_state[i] == ST_ATOM) &&
                     (ent_cnt[i] != '0)),
      .free_i       (dealloc_valid && dal_hv[i]),
      .state_o      (ent_state[i]),
      .addr_o       (ent_addr[i]),
      .mask_o       (ent_mask[i]),
      .cnt_o        (ent_cnt[i]),
      .retire_o     (retire_vec[i])
    );
  end

  // Registered forward and done pulses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_kind   <= '0;
      fwd_addr   <= '0;
      fwd_src    <= '0;
      done_valid <= 1'b0;
      done_addr  <= '0;
    end else begin
      fwd_valid  <= do_fwd;
      fwd_kind   <= req_kind;
      fwd_addr   <= req_addr;
      fwd_src    <= req_src;
      done_valid <= |retire_vec;
      done_addr  <= retire_addr;
    end
  end

  // Lookup port
  assign lookup_hit   = |lk_hv;
  assign lookup_state = lk_state;
  assign lookup_mask  = lk_mask;
  assign lookup_count = lk_cnt;

endmodule

// File: rtl/mt_tracker_chk.sv
module mt_tracker_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req_valid,
  input logic         req_ready,
  input logic         is_write,
  input logic         req_hit,
  input logic         full,
  input logic         fwd_valid,
  input logic         done_valid,
  input logic [N-1:0] req_hv,
  input logic [N-1:0] lk_hv,
  input logic [N-1:0] retire_vec
);

  assert_fwd_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(req_valid && req_ready));

  assert_write_hit_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_write && req_hit) |-> !req_ready);

  assert_one_entry_per_line_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_hv) && $onehot0(lk_hv));

  assert_single_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retire_vec));

  assert_done_after_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(|retire_vec));

  assert_full_holds_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && req_valid && !req_hit && !is_write) |-> !req_ready);

endmodule

bind mt_tracker mt_tracker_chk #(.N(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .is_write  (is_write),
  .req_hit   (req_hit),
  .full      (full),
  .fwd_valid (fwd_valid),
  .done_valid(done_valid),
  .req_hv    (req_hv),
  .lk_hv     (lk_hv),
  .retire_vec(retire_vec)
);

// File: tb/tb_mt_tracker.sv
`timescale 1ns/1ps
module tb_mt_tracker;

  localparam int ENTRIES = 4;
  localparam int AW      = 16;
  localparam int RN      = 8;
  localparam int CW      = 3;
  localparam int SW      = 3;
  localparam int MAXC    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rv = 1'b0;
  logic [1:0]    rk = '0;
  logic [AW-1:0] ra = '0;
  logic [SW-1:0] rs = '0;
  logic          av = 1'b0;
  logic [AW-1:0] aa = '0;
  logic          dv = 1'b0;
  logic [AW-1:0] da = '0;
  logic [AW-1:0] la = '0;

  logic          req_ready, lookup_hit, full, fwd_valid, done_valid;
  logic [1:0]    lookup_state, fwd_kind;
  logic [RN-1:0] lookup_mask;
  logic [CW-1:0] lookup_count;
  logic [AW-1:0] fwd_addr, done_addr;
  logic [SW-1:0] fwd_src;

  always #2 clk = ~clk;

  mt_tracker #(.ENTRIES(ENTRIES), .ADDR_W(AW), .REQ_N(RN), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(rv), .req_ready(req_ready), .req_kind(rk), .req_addr(ra), .req_src(rs),
    .ack_valid(av), .ack_addr(aa), .dealloc_valid(dv), .dealloc_addr(da),
    .lookup_addr(la), .lookup_hit(lookup_hit), .lookup_state(lookup_state),
    .lookup_mask(lookup_mask), .lookup_count(lookup_count), .full(full),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_addr(fwd_addr), .fwd_src(fwd_src),
    .done_valid(done_valid), .done_addr(done_addr));

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: keyed by line address
  int ms[int];
  int mm[int];
  int mc[int];
  bit mt[int];
  bit e_fwd = 0, e_done = 0;
  int e_fk = 0, e_fa = 0, e_fs = 0, e_da = 0;

  function automatic bit m_ready();
    if (dv && da == ra) return 1'b0;
    if (rk[1]) return !ms.exists(int'(ra));
    if (ms.exists(int'(ra))) begin
      if (rk == 2'd0) return ms[int'(ra)] != 2;
      return ms[int'(ra)] == 2 && mc[int'(ra)] < MAXC;
    end
    return ms.num() < ENTRIES;
  endfunction

  task automatic m_step(bit fire);
    int gone[$];
    bit skip_inc;
    int a;
    int sb;
    e_fwd = 0;
    e_done = 0;
    skip_inc = 0;
    a = int'(ra);
    sb = 1 << rs;
    foreach (mt[k]) begin
      if (dv && int'(da) == k) continue;
      if (fire && rk == 2'd1 && a == k) continue;
      e_done = 1;
      e_da = k;
      gone.push_back(k);
    end
    mt.delete();
    foreach (gone[j]) begin
      ms.delete(gone[j]); mm.delete(gone[j]); mc.delete(gone[j]);
    end
    if (av && ms.exists(int'(aa)) && ms[int'(aa)] == 2 && mc[int'(aa)] > 0) begin
      if (fire && rk == 2'd1 && a == int'(aa)) skip_inc = 1;
      else begin
        mc[int'(aa)]--;
        if (mc[int'(aa)] == 0 && !(dv && da == aa)) mt[int'(aa)] = 1;
      end
    end
    if (fire) begin
      e_fk = int'(rk); e_fa = a; e_fs = int'(rs);
      if (rk[1]) e_fwd = 1;
      else if (rk == 2'd0) begin
        if (!ms.exists(a)) begin
          ms[a] = 1; mm[a] = sb; mc[a] = 0; e_fwd = 1;
        end else begin
          e_fwd = ((mm[a] & ~sb) == 0);
          mm[a] |= sb;
        end
      end else begin
        if (!ms.exists(a)) begin ms[a] = 2; mm[a] = 0; mc[a] = 0; end
        mm[a] |= sb;
        if (!skip_inc) mc[a]++;
        e_fwd = 1;
      end
    end
    if (dv && ms.exists(int'(da))) begin
      ms.delete(int'(da)); mm.delete(int'(da)); mc.delete(int'(da));
      if (mt.exists(int'(da))) mt.delete(int'(da));
    end
  endtask

  // One clock: compare combinational outputs, clock, compare pulses.
  task automatic cyc();
    bit er;
    int l;
    #0.5;
    er = m_ready();
    l = int'(la);
    chk("R6 req_ready", req_ready, er);
    chk("R10 full", full, ms.num() == ENTRIES);
    chk("R11 lookup_hit", lookup_hit, ms.exists(l));
    chk("R11 lookup_state", lookup_state, ms.exists(l) ? ms[l] : 0);
    chk("R11 lookup_mask", lookup_mask, ms.exists(l) ? mm[l] : 0);
    chk("R11 lookup_count", lookup_count, ms.exists(l) ? mc[l] : 0);
    @(posedge clk);
    m_step(rv && er);
    @(negedge clk);
    chk("R2 fwd_valid", fwd_valid, e_fwd);
    if (e_fwd) begin
      chk("R2 fwd_kind", fwd_kind, e_fk);
      chk("R2 fwd_addr", fwd_addr, e_fa);
      chk("R2 fwd_src", fwd_src, e_fs);
    end
    chk("R8 done_valid", done_valid, e_done);
    if (e_done) chk("R8 done_addr", done_addr, e_da);
  endtask

  task automatic clr();
    rv = 0; av = 0; dv = 0;
  endtask

  task automatic req(logic [1:0] k, logic [AW-1:0] a, logic [SW-1:0] s);
    rv = 1; rk = k; ra = a; rs = s;
    cyc();
    clr();
  endtask

  task automatic try_req(string tag, logic [1:0] k, logic [AW-1:0] a, logic [SW-1:0] s, bit exp);
    rv = 1; rk = k; ra = a; rs = s;
    #0.5;
    chk(tag, req_ready, exp);
    cyc();
    clr();
  endtask

  task automatic ack(logic [AW-1:0] a);
    av = 1; aa = a;
    cyc();
    clr();
  endtask

  task automatic idle();
    clr();
    cyc();
  endtask

  task automatic peek(string tag, logic [AW-1:0] a, bit h, int st, int m, int c);
    la = a;
    #0.5;
    chk({tag, " hit"}, lookup_hit, h);
    chk({tag, " state"}, lookup_state, st);
    chk({tag, " mask"}, lookup_mask, m);
    chk({tag, " count"}, lookup_count, c);
  endtask

  localparam logic [AW-1:0] LA = 16'h0100, LB = 16'h0200, LC = 16'h0300,
    LD = 16'h0400, LE = 16'h0500, LF = 16'h0600, LG = 16'h0700, LH = 16'h0900;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    chk("R1 full", full, 0);
    chk("R1 lookup_hit", lookup_hit, 0);
    chk("R1 fwd_valid", fwd_valid, 0);
    chk("R1 done_valid", done_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    @(negedge clk);

    req(2'd0, LA, 3'd2);
    chk("R2 read miss forwarded", fwd_valid, 1);
    peek("R2 new entry", LA, 1, 1, 8'h04, 0);
    req(2'd0, LA, 3'd5);
    chk("R3 second reader merged", fwd_valid, 0);
    peek("R3 merged bitmap", LA, 1, 1, 8'h24, 0);
    req(2'd0, LB, 3'd1);
    req(2'd0, LB, 3'd1);
    chk("R3 same sole reader forwarded", fwd_valid, 1);

    req(2'd2, LC, 3'd0);
    chk("R4 write forwarded", fwd_valid, 1);
    chk("R4 write kind", fwd_kind, 2);
    peek("R4 write no entry", LC, 0, 0, 0, 0);
    try_req("R4 write to live line held", 2'd3, LA, 3'd7, 0);
    peek("R4 bitmap untouched", LA, 1, 1, 8'h24, 0);

    try_req("R6 atomic to read line held", 2'd1, LA, 3'd0, 0);
    req(2'd1, LD, 3'd3);
    chk("R5 atomic forwarded", fwd_valid, 1);
    req(2'd1, LD, 3'd3);
    peek("R5 atomic entry", LD, 1, 2, 8'h08, 2);
    try_req("R6 read to atomic line held", 2'd0, LD, 3'd1, 0);

    ack(LD);
    peek("R7 decrement", LD, 1, 2, 8'h08, 1);
    av = 1; aa = LD;
    req(2'd1, LD, 3'd4);
    peek("R7 same-cycle inc and dec", LD, 1, 2, 8'h18, 1);
    ack(LA);
    peek("R7 ack to read line ignored", LA, 1, 1, 8'h24, 0);
    ack(16'h0999);

    ack(LD);
    chk("R8 no done at zero edge", done_valid, 0);
    idle();
    chk("R8 done pulse", done_valid, 1);
    chk("R8 done address", done_addr, LD);
    peek("R8 entry freed", LD, 0, 0, 0, 0);

    req(2'd1, LE, 3'd0);
    ack(LE);
    req(2'd1, LE, 3'd0);
    chk("R8 trigger consumed by new atomic", done_valid, 0);
    peek("R8 entry kept", LE, 1, 2, 8'h01, 1);
    ack(LE);
    idle();
    chk("R8 done after refill", done_valid, 1);

    req(2'd1, LF, 3'd1);
    req(2'd0, LG, 3'd2);
    #0.5;
    chk("R10 full with four entries", full, 1);
    try_req("R10 miss held while full", 2'd0, 16'h0800, 3'd0, 0);
    try_req("R10 hit taken while full", 2'd0, LA, 3'd6, 1);
    peek("R10 hit merged", LA, 1, 1, 8'h64, 0);

    dv = 1; da = LA;
    try_req("R9 request to deallocated line held", 2'd0, LA, 3'd0, 0);
    peek("R9 entry freed", LA, 0, 0, 0, 0);
    req(2'd0, LA, 3'd0);
    peek("R9 bitmap cleared on reuse", LA, 1, 1, 8'h01, 0);
    ack(LF);
    dv = 1; da = LF;
    cyc();
    clr();
    idle();
    chk("R9 deallocate suppresses done", done_valid, 0);

    dv = 1; da = LB; cyc();
    da = LG; cyc();
    da = LA; cyc();
    clr();
    for (int i = 0; i < MAXC; i++) req(2'd1, LH, 3'd1);
    peek("R6 count at maximum", LH, 1, 2, 8'h02, MAXC);
    try_req("R6 atomic at maximum held", 2'd1, LH, 3'd1, 0);
    for (int i = 0; i < MAXC; i++) ack(LH);
    idle();
    chk("R8 done after saturation drain", done_valid, 1);

    for (int n = 0; n < 4000; n++) begin
      rv = ($urandom % 2) == 0;
      rk = 2'($urandom % 4);
      ra = AW'(16'h0010 + ($urandom % 6));
      rs = SW'($urandom % 8);
      av = ($urandom % 3) == 0;
      aa = AW'(16'h0010 + ($urandom % 6));
      dv = ($urandom % 12) == 0;
      da = AW'(16'h0010 + ($urandom % 6));
      la = AW'(16'h0010 + ($urandom % 6));
      cyc();
    end
    clr();
    idle();

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule